// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns byte-wide packets into a serial HDLC bit stream and sends one line bit per clock. It reads bytes from a show-ahead transmit FIFO, and each byte carries a tag that marks the end of a packet. The block computes a 16-bit CRC over the payload and appends it as the frame check sequence. It inserts a zero after any run of five ones inside the frame and wraps the frame between opening and closing flags. When there is nothing to send, the line is held at one.

Idle, flag and abort patterns, stuffing zeros, payload bits and check bits all go through one bit selector to a single registered output. A strobe runs alongside the line and marks the last bit of each complete frame. A control request, or a FIFO that runs dry in the middle of a packet, cuts the frame off with an abort pattern. An FIFO underrun also raises a one-cycle flag.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After reset `tx_bit` is 1 and `frame_end`, `underrun` and `fifo_rd` are 0. While `tx_en` is low and no frame is in progress, no frame starts, the FIFO is not read and the line stays at 1.
- R2: A frame starts when `tx_en` is high and `fifo_empty` is low. Every frame opens with the flag 01111110, so the first line bit of a frame is 0.
- R3: `fifo_data` and `fifo_last` are valid whenever `fifo_empty` is low. A byte is consumed by `fifo_rd` high in the same cycle, and `fifo_rd` is never high while the FIFO is empty. Bytes go out in FIFO order, each with its least significant bit first.
- R4: Between the opening and closing flags, a 0 is inserted after every five consecutive 1s, counted over payload and check bits together. This includes a run that ends on the last check bit. Flags and abort patterns are never stuffed.
- R5: The check sequence follows the byte tagged by `fifo_last`. It is a CRC register preset to 0xFFFF with polynomial x^16+x^12+x^5+1, updated with each payload bit before stuffing, and sent complemented with its most significant bit first.
- R6: The closing flag 01111110 follows the check sequence. After it the line carries at least one 1 before any new opening flag, and carries only 1s while nothing is pending.
- R7: `frame_end` is high for exactly one cycle: the cycle in which the last bit of the closing flag is on `tx_bit`.
- R8: An `abort_req` sampled high during a frame (opening flag through closing flag) makes the next line bit the start of 011111111. The line then idles at 1. No further byte is read for that frame and `frame_end` is not raised.
- R9: `abort_req` has no effect while the transmitter is idle or already sending an abort pattern.
- R10: If a byte is needed, the previous byte was untagged and the FIFO is empty, the frame is aborted. `underrun` is high for the one cycle in which the last payload bit is on the line, and 011111111 follows immediately.
- R11: Lowering `tx_en` during a frame does not shorten that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Permits a new frame to start |
| abort_req | input | 1 | Request to cut off the current frame |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | DATA_W | Byte at the FIFO head |
| fifo_last | input | 1 | Head byte ends its packet |
| fifo_rd | output | 1 | Consumes the head byte this cycle |
| tx_bit | output | 1 | Serial line output |
| frame_end | output | 1 | Marks the final bit of a completed frame |
| underrun | output | 1 | One-cycle pulse when a frame is cut off for lack of data |

## Verification
The hardest cases to reach from the ports are those where stuffing meets a boundary. One is a run of five ones ending on the last check bit, which forces a zero before the closing flag. Another is a FIFO that drains just as a byte ends on a run of ones. The stimulus uses payloads of all-ones and flag-valued bytes, untagged packets that run the FIFO dry, and seeded random frames of 1 to 16 bytes. Every bit of each frame is compared with a stream built in the bench from the payload, including stuffing and CRC.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  // Sequencer phases of one frame
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

  // Source feeding the shared line bit path
  typedef enum logic [2:0] {
    LN_IDLE,
    LN_FLAG,
    LN_ABORT,
    LN_STUFF,
    LN_DATA,
    LN_FCS
  } line_sel_e;

endpackage

// File: rtl/hdlc_crc_serial.sv
module hdlc_crc_serial #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic shift,
  input  logic bit_in,
  output logic msb_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] step;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ bit_in;

  // Feedback XOR sits only on the bits the polynomial selects
  generate
    if (POLY[0]) begin : g_tap0
      assign step[0] = fb;
    end else begin : g_pass0
      assign step[0] = 1'b0;
    end
    for (genvar i = 1; i < CRC_W; i++) begin : g_bit
      if (POLY[i]) begin : g_tap
        assign step[i] = crc_q[i-1] ^ fb;
      end else begin : g_pass
        assign step[i] = crc_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = INIT;
    end else if (upd) begin
      crc_d = step;
    end else if (shift) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign msb_o = crc_q[CRC_W-1];

endmodule

// File: rtl/hdlc_stuff_ctr.sv
module hdlc_stuff_ctr #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bit_in,
  output logic due
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (clr) begin
      run_d = '0;
    end else if (adv) begin
      run_d = bit_in ? run_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  assign due = (run_q == CW'(RUN));

endmodule

// File: rtl/hdlc_line_mux.sv
module hdlc_line_mux
  import hdlc_tx_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int FLAG_W = 8
) (
  input  line_sel_e          sel,
  input  logic [CNT_W-1:0]   idx,
  input  logic               data_bit,
  input  logic               fcs_msb,
  output logic               line_bit
);

  always_comb begin
    case (sel)
      LN_IDLE:  line_bit = 1'b1;
      // flag: zero at both ends, ones between
      LN_FLAG:  line_bit = !((idx == '0) || (idx == CNT_W'(FLAG_W - 1)));
      // abort: one zero then ones
      LN_ABORT: line_bit = (idx != '0);
      LN_STUFF: line_bit = 1'b0;
      LN_DATA:  line_bit = data_bit;
      LN_FCS:   line_bit = ~fcs_msb;
      default:  line_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter int               STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              abort_req,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_rd,
  output logic              tx_bit,
  output logic              frame_end,
  output logic              underrun
);

  localparam int ABORT_LEN = DATA_W + 1;
  localparam int CNT_MAX   = (CRC_W > ABORT_LEN) ? CRC_W : ABORT_LEN;
  localparam int CNT_W     = $clog2(CNT_MAX);
  localparam int BIDX_W    = $clog2(DATA_W);

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rs_q[1];

  tx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIDX_W-1:0]  bidx_q, bidx_d;
  logic [DATA_W-1:0]  sh_q;
  logic               last_q;
  logic               tx_bit_q;
  logic               fend_q, fend_d;
  logic               und_q, und_d;

  line_sel_e          sel;
  logic [CNT_W-1:0]   line_idx;
  logic               line_bit;
  logic               data_bit;
  logic               fcs_msb;
  logic               rd;
  logic               crc_init, crc_upd, crc_shift;
  logic               stf_clr, stf_adv, stuff_due;
  logic               in_frame;

  assign data_bit = sh_q[bidx_q];
  assign in_frame = (state_q == ST_OPEN) || (state_q == ST_DATA) ||
                    (state_q == ST_FCS)  || (state_q == ST_CLOSE);

  hdlc_crc_serial #(
    .CRC_W (CRC_W),
    .POLY  (CRC_POLY),
    .INIT  (CRC_INIT)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .init   (crc_init),
    .upd    (crc_upd),
    .shift  (crc_shift),
    .bit_in (data_bit),
    .msb_o  (fcs_msb)
  );

  hdlc_stuff_ctr #(
    .RUN (STUFF_RUN)
  ) u_stuff (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (stf_clr),
    .adv    (stf_adv),
    .bit_in (line_bit),
    .due    (stuff_due)
  );

  hdlc_line_mux #(
    .CNT_W  (CNT_W),
    .FLAG_W (DATA_W)
  ) u_mux (
    .sel      (sel),
    .idx      (line_idx),
    .data_bit (data_bit),
    .fcs_msb  (fcs_msb),
    .line_bit (line_bit)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bidx_d    = bidx_q;
    sel       = LN_IDLE;
    line_idx  = cnt_q;
    rd        = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_shift = 1'b0;
    stf_clr   = 1'b0;
    stf_adv   = 1'b0;
    fend_d    = 1'b0;
    und_d     = 1'b0;

    if (abort_req && in_frame) begin
      // first abort bit leaves in this very cycle
      sel      = LN_ABORT;
      line_idx = '0;
      state_d  = ST_ABORT;
      cnt_d    = CNT_W'(1);
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (tx_en && !fifo_empty) begin
            state_d = ST_OPEN;
            cnt_d   = '0;
          end
        end

        ST_OPEN: begin
          sel      = LN_FLAG;
          crc_init = 1'b1;
          stf_clr  = 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            if (!fifo_empty) begin
              rd      = 1'b1;
              bidx_d  = '0;
              state_d = ST_DATA;
            end else begin
              und_d   = 1'b1;
              state_d = ST_ABORT;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end

        ST_DATA: begin
          if (stuff_due) begin
            sel     = LN_STUFF;
            stf_clr = 1'b1;
          end else begin
            sel     = LN_DATA;
            crc_upd = 1'b1;
            stf_adv = 1'b1;
            if (bidx_q == BIDX_W'(DATA_W - 1)) begin
              if (last_q) begin
                state_d = ST_FCS;
                cnt_d   = '0;
              end else if (!fifo_empty) begin
                rd     = 1'b1;
                bidx_d = '0;
              end else begin
                und_d   = 1'b1;
                state_d = ST_ABORT;
                cnt_d   = '0;
              end
            end else begin
              bidx_d = bidx_q + 1'b1;
            end
          end
        end

        ST_FCS: begin
          if (stuff_due) begin
            sel     = LN_STUFF;
            stf_clr = 1'b1;
          end else begin
            sel       = LN_FCS;
            crc_shift = 1'b1;
            stf_adv   = 1'b1;
            if (cnt_q == CNT_W'(CRC_W - 1)) begin
              state_d = ST_CLOSE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_CLOSE: begin
          if (stuff_due) begin
            // a run ending on the last check bit still needs its zero
            sel     = LN_STUFF;
            stf_clr = 1'b1;
          end else begin
            sel = LN_FLAG;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              fend_d  = 1'b1;
              state_d = ST_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end

        ST_ABORT: begin
          sel = LN_ABORT;
          if (cnt_q == CNT_W'(ABORT_LEN - 1)) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end

        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bidx_q   <= '0;
      tx_bit_q <= 1'b1;
      fend_q   <= 1'b0;
      und_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      bidx_q   <= bidx_d;
      tx_bit_q <= line_bit;
      fend_q   <= fend_d;
      und_q    <= und_d;
    end
  end

  // byte holding register, loaded only on a FIFO read
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else if (rd) begin
      sh_q   <= fifo_data;
      last_q <= fifo_last;
    end
  end

  assign fifo_rd   = rd;
  assign tx_bit    = tx_bit_q;
  assign frame_end = fend_q;
  assign underrun  = und_q;

endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic abort_req,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic tx_bit,
  input logic frame_end,
  input logic underrun,
  input logic in_frame,
  input logic is_idle
);

  p_disabled_stays_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !tx_en) |=> is_idle);

  p_read_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  p_frame_end_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !tx_bit);

  p_frame_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_abort_starts_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && in_frame) |=> (!tx_bit && !frame_end));

  p_idle_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> tx_bit);

  p_underrun_then_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> (!tx_bit && !underrun));

endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tx_en      (tx_en),
  .abort_req  (abort_req),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .tx_bit     (tx_bit),
  .frame_end  (frame_end),
  .underrun   (underrun),
  .in_frame   (in_frame),
  .is_idle    (state_q == hdlc_tx_pkg::ST_IDLE)
);

// File: tb/sim_hdlc_frame_tx.sv
`timescale 1ns/1ps
module sim_hdlc_frame_tx;

  logic       clk;
  logic       rst_n;
  logic       tx_en;
  logic       abort_req;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_last;
  logic       fifo_rd;
  logic       tx_bit;
  logic       frame_end;
  logic       underrun;

  int total = 0;
  int fails = 0;

  // show-ahead FIFO model
  logic [8:0] fmem [0:1023];
  logic [9:0] wp;
  logic [9:0] rp;
  logic       flush_req;

  assign fifo_empty = (rp == wp);
  assign fifo_data  = fmem[rp][7:0];
  assign fifo_last  = fmem[rp][8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rp <= '0;
    else if (flush_req) rp <= wp;
    else if (fifo_rd)   rp <= rp + 1'b1;
  end

  hdlc_frame_tx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .abort_req  (abort_req),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_last  (fifo_last),
    .fifo_rd    (fifo_rd),
    .tx_bit     (tx_bit),
    .frame_end  (frame_end),
    .underrun   (underrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bit exp_q[$];
  bit got[$];
  bit gfe[$];
  bit gun[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected line bits for one frame, from the requirements
  task automatic build_exp(input logic [7:0] b[$], input bit good);
    bit raw[$];
    logic [15:0] crc;
    bit fb;
    int ones;
    logic [7:0] flag;
    flag = 8'h7E;
    exp_q.delete();
    for (int k = 0; k < 8; k++) exp_q.push_back(flag[k]);
    crc = 16'hFFFF;
    foreach (b[i]) begin
      for (int k = 0; k < 8; k++) begin
        raw.push_back(b[i][k]);
        fb  = crc[15] ^ b[i][k];
        crc = {crc[14:0], 1'b0};
        if (fb) crc = crc ^ 16'h1021;
      end
    end
    if (good) begin
      for (int k = 15; k >= 0; k--) raw.push_back(~crc[k]);
    end
    ones = 0;
    for (int i = 0; i < raw.size(); i++) begin
      exp_q.push_back(raw[i]);
      ones = raw[i] ? ones + 1 : 0;
      if (ones == 5) begin
        if (good || i != raw.size() - 1) exp_q.push_back(1'b0);
        ones = 0;
      end
    end
    if (good) begin
      for (int k = 0; k < 8; k++) exp_q.push_back(flag[k]);
    end else begin
      exp_q.push_back(1'b0);
      for (int k = 0; k < 8; k++) exp_q.push_back(1'b1);
    end
  endtask

  task automatic push_frame(input logic [7:0] b[$], input bit tag);
    foreach (b[i]) begin
      fmem[wp] = {tag && (i == b.size() - 1), b[i]};
      wp = wp + 1'b1;
    end
  endtask

  // wait for the first zero, then record n line bits
  task automatic capture(input int n, input bit drop_en);
    int w;
    got.delete(); gfe.delete(); gun.delete();
    w = 0;
    @(negedge clk);
    while (tx_bit !== 1'b0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 3000) begin
      chk(1'b0, "R2", "frame never started", w, 0);
      return;
    end
    if (drop_en) tx_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      got.push_back(tx_bit);
      gfe.push_back(frame_end);
      gun.push_back(underrun);
    end
  endtask

  task automatic run_frame(input logic [7:0] b[$], input bit good, input bit do_push,
                           input bit drop_en, input string req);
    int bad, nfe, nun, pos;
    build_exp(b, good);
    if (do_push) push_frame(b, good);
    tx_en = 1'b1;
    capture(exp_q.size(), drop_en);
    bad = -1;
    for (int i = 0; i < got.size(); i++)
      if (bad < 0 && got[i] !== exp_q[i]) bad = i;
    chk(bad < 0 && got.size() == exp_q.size(), req, "first bad line bit index", bad, -1);
    nfe = 0; nun = 0; pos = -1;
    for (int i = 0; i < got.size(); i++) begin
      if (gfe[i]) nfe++;
      if (gun[i]) begin nun++; pos = i; end
    end
    if (good) begin
      chk(nfe == 1 && got.size() > 0 && gfe[got.size()-1], "R7", "frame_end count", nfe, 1);
      chk(nun == 0, "R10", "underrun in good frame", nun, 0);
    end else begin
      chk(nfe == 0, "R10", "frame_end on aborted frame", nfe, 0);
      chk(nun == 1 && pos == exp_q.size() - 10, "R10", "underrun position", pos,
          exp_q.size() - 10);
    end
    @(negedge clk);
    chk(tx_bit === 1'b1, "R6", "line high after frame", tx_bit, 1);
    tx_en = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] b[$];
    logic [9:0] rp_snap;
    int n, nfe, mode;
    bit ok;

    void'($urandom(32'd4242));
    rst_n = 1'b0; tx_en = 1'b0; abort_req = 1'b0; flush_req = 1'b0; wp = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_bit === 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    chk(frame_end === 1'b0 && underrun === 1'b0, "R1", "strobes in reset",
        frame_end | underrun, 0);
    chk(fifo_rd === 1'b0, "R1", "fifo_rd in reset", fifo_rd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 disabled: data waiting, nothing sent
    b = '{8'hA5, 8'h3C};
    push_frame(b, 1'b1);
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_bit !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R1", "line high while disabled", ok, 1);
    chk(rp == 10'd0, "R1", "reads while disabled", rp, 0);
    run_frame(b, 1'b1, 1'b0, 1'b0, "R2 R3 R5 first frame");

    // R4 heavy stuffing
    b = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_frame(b, 1'b1, 1'b1, 1'b0, "R4 all-ones payload");
    b = '{8'h7E, 8'h7E};
    run_frame(b, 1'b1, 1'b1, 1'b0, "R4 flag-valued payload");
    b = '{8'h00};
    run_frame(b, 1'b1, 1'b1, 1'b0, "R5 single zero byte");
    b = '{8'h01, 8'h80, 8'hF8, 8'h1F};
    run_frame(b, 1'b1, 1'b1, 1'b0, "R3 bit order");
    // R11 enable dropped right after start
    b.delete();
    for (int i = 0; i < 16; i++) b.push_back(8'($urandom));
    run_frame(b, 1'b1, 1'b1, 1'b1, "R11 enable dropped mid-frame");

    // R6 back-to-back frames queued together
    begin
      logic [7:0] b1[$];
      logic [7:0] b2[$];
      b1 = '{8'h12, 8'h34, 8'h56};
      b2 = '{8'hFE, 8'hDC};
      push_frame(b1, 1'b1);
      push_frame(b2, 1'b1);
      run_frame(b1, 1'b1, 1'b0, 1'b0, "R6 first of pair");
      run_frame(b2, 1'b1, 1'b0, 1'b0, "R6 second of pair");
    end

    // R8 abort in the middle of a frame
    b.delete();
    for (int i = 0; i < 12; i++) b.push_back(8'h5A);
    push_frame(b, 1'b1);
    tx_en = 1'b1;
    n = 0;
    @(negedge clk);
    while (tx_bit !== 1'b0 && n < 100) begin @(negedge clk); n++; end
    repeat (30) @(negedge clk);
    tx_en = 1'b0;
    abort_req = 1'b1;
    rp_snap = rp;
    @(negedge clk);
    abort_req = 1'b0;
    chk(tx_bit === 1'b0, "R8", "abort first bit", tx_bit, 0);
    ok = 1'b1; nfe = 0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (tx_bit !== 1'b1) ok = 1'b0;
      if (frame_end) nfe++;
    end
    chk(ok, "R8", "abort ones then idle", ok, 1);
    chk(nfe == 0, "R8", "frame_end after abort", nfe, 0);
    chk(rp == rp_snap, "R8", "bytes read after abort", rp - rp_snap, 0);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;

    // R9 abort while idle is ignored
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (tx_bit !== 1'b1) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R9", "line during idle abort", ok, 1);

    // R10 underrun: untagged packets
    b = '{8'h11, 8'h22, 8'h33};
    run_frame(b, 1'b0, 1'b1, 1'b0, "R10 underrun after three bytes");
    b = '{8'h1F};
    run_frame(b, 1'b0, 1'b1, 1'b0, "R10 underrun on run of ones");
    b = '{8'hFF, 8'hFF};
    run_frame(b, 1'b0, 1'b1, 1'b0, "R10 underrun all ones");

    // seeded random frames, some biased towards long runs of ones
    for (int f = 0; f < 24; f++) begin
      b.delete();
      n = 1 + int'($urandom % 16);
      mode = int'($urandom % 4);
      for (int i = 0; i < n; i++) begin
        if (mode == 0) b.push_back(8'hFF);
        else if (mode == 1) b.push_back(($urandom % 2) ? 8'h7E : 8'hFF);
        else b.push_back(8'($urandom));
      end
      run_frame(b, 1'b1, 1'b1, 1'b0, "R3 R4 R5 random frame");
    end

    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule